// File: doc/BRIEF.md
# Synchronous Tag Memory with Compare Output

This block is a small synchronous tag store for a cache controller. Each location holds an 18-bit word made of two 9-bit lanes. Every input is sampled on the rising clock edge. A cycle starts when one of two address strobes is low. The host strobe always reads. The controller strobe reads or writes, depending on the write controls. Once a cycle has been started, later cycles with no strobe continue it. The step input then either holds the address (wait) or takes the low two address bits from an external burst sequencer (advance).

The data pins carry the write data. They also feed a compare register, which loads only while its load enable is low. In every active cycle the word stored at the addressed location is read out on the registered output one clock later. On the same clock the match output reports whether that word equals the compare register. Writes are read-first, so a compare or read that hits the location being written sees the word as it was before the write.

Top module: `tag_match_ram`

## Requirements
- R1: The block is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A strobe accepted while not selected deselects the block: no write happens, `match` is 0 on the next cycle and `rd_data` keeps its value. Later cycles with no strobe do nothing until a strobe selects the block again.
- R2: A host strobe (`strb_host_n`=0 while `sel_a_n`=0) loads `addr` and performs a read, never a write, whatever the write controls are. It takes priority over a controller strobe in the same cycle. While `sel_a_n`=1, `strb_host_n` is ignored.
- R3: A controller strobe (`strb_ctl_n`=0 without an accepted host strobe) loads `addr`. It writes when a write control is active and otherwise reads.
- R4: `wr_all_n`=0 writes all 18 bits, whatever `wr_gate_n`, `wr_lo_n` and `wr_hi_n` are.
- R5: With `wr_all_n`=1 and `wr_gate_n`=0, `wr_lo_n`=0 writes bits [8:0] and `wr_hi_n`=0 writes bits [17:9]. A lane whose enable is 1 is left unchanged. With `wr_all_n`=1 and `wr_gate_n`=1 the cycle is a read.
- R6: The compare register loads `cmp_data` only on an edge where `cmp_load_n`=0. Otherwise it holds.
- R7: In an active cycle, `rd_data` on the following cycle shows the word stored at the cycle address before that edge's write (read-first). Any write in the cycle is visible to later reads.
- R8: `match` is 1 on the cycle after an active cycle in which `match_en_n`=0 and the old stored word equals the compare register's value before that edge. In every other case it is 0.
- R9: In a continuation cycle (block active, no strobe), `step_n`=0 takes the low two address bits from `burst_lo` and keeps the upper bits. `step_n`=1 holds the whole address. The operation follows the write controls.
- R10: Synchronous reset clears `rd_data`, `match` and the compare register to 0, and leaves the block inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Active-low select, also qualifies the host strobe |
| sel_b_n | input | 1 | Active-low select |
| sel_c | input | 1 | Active-high select |
| strb_host_n | input | 1 | Active-low host address strobe (read only) |
| strb_ctl_n | input | 1 | Active-low controller address strobe |
| step_n | input | 1 | Active-low burst advance; high means wait |
| burst_lo | input | 2 | Low address bits from the external burst sequencer |
| addr | input | ADDR_W | Location address |
| wr_all_n | input | 1 | Active-low full-word write |
| wr_gate_n | input | 1 | Active-low gate for the lane write enables |
| wr_lo_n | input | 1 | Active-low write enable for bits [8:0] |
| wr_hi_n | input | 1 | Active-low write enable for bits [17:9] |
| cmp_data | input | 18 | Write data and compare register input |
| cmp_load_n | input | 1 | Active-low compare register load |
| match_en_n | input | 1 | Active-low match enable |
| rd_data | output | 18 | Registered read word |
| match | output | 1 | Registered-path compare result |

## Verification
The hardest situation to reach from the ports is a compare that hits the same location a write is changing on the same edge. The compare register is also loaded on that edge, so three values meet at once. Directed sequences build this case by loading the compare register with a known word and then issuing a controller-strobe write of a different word to that address with match enabled. They also cover deselect followed by continuation cycles and burst advances, which leave the memory untouched or redirect the address. A long random run then mixes every control with biased probabilities, so these collisions recur.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
  localparam int LANE_W  = 9;
  localparam int LANES   = 2;
  localparam int DATA_W  = LANE_W * LANES;
  localparam int BURST_W = 2;

  typedef logic [LANES-1:0] lane_mask_t;
endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_a_n,
  input  logic               sel_b_n,
  input  logic               sel_c,
  input  logic               strb_host_n,
  input  logic               strb_ctl_n,
  input  logic               step_n,
  input  logic [BURST_W-1:0] burst_lo,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_all_n,
  input  logic               wr_gate_n,
  input  logic               wr_lo_n,
  input  logic               wr_hi_n,
  output logic               cyc_go,
  output logic [ADDR_W-1:0]  cyc_addr,
  output lane_mask_t         lane_we
);
  logic              act_q;
  logic [ADDR_W-1:0] cur_q;
  logic              selected, host_take, any_strobe, act_d;
  lane_mask_t        req_we;

  always_comb begin
    selected   = !sel_a_n && !sel_b_n && sel_c;
    host_take  = !strb_host_n && !sel_a_n;
    any_strobe = host_take || !strb_ctl_n;
    req_we[0]  = !wr_all_n || (!wr_gate_n && !wr_lo_n);
    req_we[1]  = !wr_all_n || (!wr_gate_n && !wr_hi_n);
    cyc_go     = 1'b0;
    cyc_addr   = cur_q;
    lane_we    = '0;
    act_d      = act_q;
    if (any_strobe) begin
      cyc_go   = selected;
      act_d    = selected;
      cyc_addr = addr;
      lane_we  = (selected && !host_take) ? req_we : '0;
    end else if (act_q) begin
      cyc_go   = 1'b1;
      cyc_addr = step_n ? cur_q : {cur_q[ADDR_W-1:BURST_W], burst_lo};
      lane_we  = req_we;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      cur_q <= '0;
    end else begin
      act_q <= act_d;
      if (cyc_go) cur_q <= cyc_addr;
    end
  end

  AST_HOST_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
    (!strb_host_n && !sel_a_n) |-> (lane_we == '0)); // R2
  AST_FULL_WORD_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cyc_go && !wr_all_n && !(!strb_host_n && !sel_a_n)) |-> (lane_we == '1)); // R4
  AST_DESELECT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!(!sel_a_n && !sel_b_n && sel_c) && (!strb_ctl_n || (!strb_host_n && !sel_a_n)))
      |-> (lane_we == '0 && !cyc_go)); // R1
  AST_IDLE_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (!act_q && strb_ctl_n && (strb_host_n || sel_a_n)) |-> (!cyc_go && lane_we == '0)); // R10
  AST_WAIT_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    ($past(cyc_go) && act_q && strb_ctl_n && (strb_host_n || sel_a_n) && step_n)
      |-> (cyc_addr == $past(cyc_addr))); // R9
endmodule

// File: rtl/tagram_array.sv
module tagram_array
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  lane_mask_t        we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst)        rd_q <= '0;
      else if (rd_en) rd_q <= mem[addr];
    end

    assign rdata[g*LANE_W +: LANE_W] = rd_q;
  end

  AST_WRITE_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (we != '0) |-> rd_en); // R7
endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp
  import tagram_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic              cmp_load_n,
  input  logic              cyc_go,
  input  logic              match_en_n,
  input  logic [DATA_W-1:0] stored,
  output logic              match
);
  logic [DATA_W-1:0] ref_q, snap_q;
  logic              chk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q  <= '0;
      snap_q <= '0;
      chk_q  <= 1'b0;
    end else begin
      snap_q <= ref_q;
      chk_q  <= cyc_go && !match_en_n;
      if (!cmp_load_n) ref_q <= cmp_data;
    end
  end

  assign match = chk_q && (stored == snap_q);

  AST_REF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cmp_load_n |=> $stable(ref_q)); // R6
endmodule

// File: rtl/tag_match_ram.sv
module tag_match_ram
  import tagram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sel_a_n,
  input  logic               sel_b_n,
  input  logic               sel_c,
  input  logic               strb_host_n,
  input  logic               strb_ctl_n,
  input  logic               step_n,
  input  logic [BURST_W-1:0] burst_lo,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_all_n,
  input  logic               wr_gate_n,
  input  logic               wr_lo_n,
  input  logic               wr_hi_n,
  input  logic [DATA_W-1:0]  cmp_data,
  input  logic               cmp_load_n,
  input  logic               match_en_n,
  output logic [DATA_W-1:0]  rd_data,
  output logic               match
);
  logic              cyc_go;
  logic [ADDR_W-1:0] cyc_addr;
  lane_mask_t        lane_we;

  tagram_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n),
    .step_n(step_n), .burst_lo(burst_lo), .addr(addr),
    .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
    .cyc_go(cyc_go), .cyc_addr(cyc_addr), .lane_we(lane_we)
  );

  tagram_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .rst(rst), .rd_en(cyc_go), .we(lane_we),
    .addr(cyc_addr), .wdata(cmp_data), .rdata(rd_data)
  );

  tagram_cmp u_cmp (
    .clk(clk), .rst(rst), .cmp_data(cmp_data), .cmp_load_n(cmp_load_n),
    .cyc_go(cyc_go), .match_en_n(match_en_n), .stored(rd_data), .match(match)
  );

  AST_IDLE_MATCH_LOW: assert property (@(posedge clk) disable iff (rst)
    !cyc_go |=> !match); // R8
  AST_IDLE_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !cyc_go |=> $stable(rd_data)); // R1
  AST_DISABLED_MATCH_LOW: assert property (@(posedge clk) disable iff (rst)
    match_en_n |=> !match); // R8
endmodule

// File: tb/tag_match_ram_tb.sv
`timescale 1ns/1ps
module tag_match_ram_tb;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_a_n, sel_b_n, sel_c, strb_host_n, strb_ctl_n, step_n;
  logic [1:0] burst_lo;
  logic [AW-1:0] addr;
  logic wr_all_n, wr_gate_n, wr_lo_n, wr_hi_n, cmp_load_n, match_en_n;
  logic [17:0] cmp_data, rd_data;
  logic match;

  int n_chk = 0, n_bad = 0;

  logic [17:0] m_mem [DEPTH];
  logic        m_act = 1'b0;
  logic [AW-1:0] m_cur = '0;
  logic [17:0] m_ref = '0, exp_rd = '0;
  logic        exp_match = 1'b0;

  always #4 clk = ~clk;

  tag_match_ram #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
    .burst_lo(burst_lo), .addr(addr), .wr_all_n(wr_all_n), .wr_gate_n(wr_gate_n),
    .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n), .cmp_data(cmp_data),
    .cmp_load_n(cmp_load_n), .match_en_n(match_en_n), .rd_data(rd_data), .match(match)
  );

  function automatic logic [17:0] pat(input int i);
    return 18'(i * 18'h0ABC) ^ 18'h15A5A;
  endfunction

  task automatic chk(input string req, input logic [17:0] act, input logic [17:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic quiet();
    sel_a_n = 0; sel_b_n = 0; sel_c = 1; strb_host_n = 1; strb_ctl_n = 1;
    step_n = 1; burst_lo = 0; addr = 0; wr_all_n = 1; wr_gate_n = 1;
    wr_lo_n = 1; wr_hi_n = 1; cmp_data = 0; cmp_load_n = 1; match_en_n = 0;
  endtask

  // Applies one clock of the current inputs, predicting from the requirements.
  task automatic step(input string req);
    logic sel, host, strobe, go;
    logic [AW-1:0] eff;
    logic [1:0] we, want;
    sel    = !sel_a_n && !sel_b_n && sel_c;
    host   = !strb_host_n && !sel_a_n;
    strobe = host || !strb_ctl_n;
    want   = {!wr_all_n || (!wr_gate_n && !wr_hi_n), !wr_all_n || (!wr_gate_n && !wr_lo_n)};
    go = 0; we = 0; eff = m_cur;
    if (strobe) begin
      go = sel; eff = addr; we = (sel && !host) ? want : 2'b00; m_act = sel;
    end else if (m_act) begin
      go = 1; eff = step_n ? m_cur : {m_cur[AW-1:2], burst_lo}; we = want;
    end
    exp_match = 0;
    if (go) begin
      exp_rd = m_mem[eff];
      exp_match = !match_en_n && (m_mem[eff] == m_ref);
      if (we[0]) m_mem[eff][8:0]  = cmp_data[8:0];
      if (we[1]) m_mem[eff][17:9] = cmp_data[17:9];
      m_cur = eff;
    end
    if (!cmp_load_n) m_ref = cmp_data;
    @(posedge clk);
    @(negedge clk);
    chk({req, " rd_data"}, rd_data, exp_rd);
    chk({req, " match"}, {17'd0, match}, {17'd0, exp_match});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [17:0] d, input string req);
    quiet(); strb_ctl_n = 0; addr = a; cmp_data = d; wr_all_n = 0; step(req);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    quiet(); strb_ctl_n = 0; addr = a; step(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    quiet();
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 'x;
    repeat (3) @(negedge clk);
    rst = 0;
    // R10: reset state, and no activity without a strobe
    chk("R10 rd_data", rd_data, 18'd0);
    chk("R10 match", {17'd0, match}, 18'd0);
    wr_all_n = 0; cmp_data = 18'h3FFFF; step("R10 idle");
    // R3/R4: fill memory with global writes
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), pat(i), "R3");
    for (int i = 0; i < DEPTH; i++) begin
      rd(AW'(i), "R7");
      chk("R4 fill", rd_data, pat(i));
    end
    // R4: global write wins over lane controls
    quiet(); strb_ctl_n = 0; addr = 5; cmp_data = 18'h2AAAA; wr_all_n = 0;
    wr_gate_n = 0; wr_lo_n = 1; wr_hi_n = 1; step("R4");
    rd(5, "R4"); chk("R4 full", rd_data, 18'h2AAAA);
    // R5: low lane only, high lane only, gate off
    quiet(); strb_ctl_n = 0; addr = 6; cmp_data = 18'h3FFFF; wr_gate_n = 0; wr_lo_n = 0; step("R5");
    rd(6, "R5"); chk("R5 low lane", rd_data, {pat(6)[17:9], 9'h1FF});
    quiet(); strb_ctl_n = 0; addr = 7; cmp_data = 18'h00000; wr_gate_n = 0; wr_hi_n = 0; step("R5");
    rd(7, "R5"); chk("R5 high lane", rd_data, {9'h000, pat(7)[8:0]});
    quiet(); strb_ctl_n = 0; addr = 8; cmp_data = 18'h1; wr_lo_n = 0; wr_hi_n = 0; step("R5");
    rd(8, "R5"); chk("R5 gate off", rd_data, pat(8));
    // R2: host strobe never writes and beats controller strobe
    quiet(); strb_host_n = 0; strb_ctl_n = 0; addr = 9; cmp_data = 18'h0; wr_all_n = 0; step("R2");
    rd(9, "R2"); chk("R2 no write", rd_data, pat(9));
    // R2: host strobe ignored when sel_a_n high (acts as no strobe -> continuation)
    quiet(); sel_a_n = 1; strb_host_n = 0; addr = 20; step("R2 ignored");
    chk("R2 ignored addr", rd_data, pat(9));
    // R1: deselect, then continuation cycles with write controls do nothing
    quiet(); sel_c = 0; strb_ctl_n = 0; addr = 10; wr_all_n = 0; cmp_data = 0; step("R1 deselect");
    quiet(); wr_all_n = 0; cmp_data = 0; step("R1 idle");
    step("R1 idle");
    rd(10, "R1"); chk("R1 no write", rd_data, pat(10));
    // R6/R8: compare register load and hold
    quiet(); cmp_data = pat(12); cmp_load_n = 0; step("R6 load");
    rd(12, "R8"); chk("R8 hit", {17'd0, match}, 18'd1);
    quiet(); strb_ctl_n = 0; addr = 12; cmp_data = 18'h0; cmp_load_n = 1; step("R6");
    chk("R6 hold", {17'd0, match}, 18'd1);
    quiet(); strb_ctl_n = 0; addr = 12; match_en_n = 1; step("R8 disabled");
    chk("R8 disabled", {17'd0, match}, 18'd0);
    rd(13, "R8"); chk("R8 miss", {17'd0, match}, 18'd0);
    // R7: write to compared location sees old word
    quiet(); strb_ctl_n = 0; addr = 12; cmp_data = 18'h12345; wr_all_n = 0; cmp_load_n = 0; step("R7");
    chk("R7 old word", rd_data, pat(12));
    chk("R7 old compare", {17'd0, match}, 18'd1);
    rd(12, "R7"); chk("R7 new word", rd_data, 18'h12345);
    // R9: burst advance and wait
    rd(16, "R9");
    quiet(); step_n = 0; burst_lo = 2'd3; step("R9");
    chk("R9 advance", rd_data, pat(19));
    quiet(); step("R9 wait"); chk("R9 wait", rd_data, pat(19));
    quiet(); step_n = 0; burst_lo = 2'd1; wr_all_n = 0; cmp_data = 18'h0F0F0; step("R9");
    rd(17, "R9"); chk("R9 burst write", rd_data, 18'h0F0F0);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      sel_a_n = ($urandom % 8) == 0; sel_b_n = ($urandom % 10) == 0; sel_c = ($urandom % 10) != 0;
      strb_host_n = ($urandom % 4) != 0; strb_ctl_n = ($urandom % 3) != 0;
      step_n = $urandom % 2; burst_lo = 2'($urandom); addr = AW'($urandom % 24);
      wr_all_n = ($urandom % 4) != 0; wr_gate_n = $urandom % 2;
      wr_lo_n = $urandom % 2; wr_hi_n = $urandom % 2;
      cmp_data = ($urandom % 2) ? pat($urandom % 24) : 18'($urandom);
      cmp_load_n = ($urandom % 3) != 0; match_en_n = ($urandom % 5) == 0;
      step("R8 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule